// File: doc/BRIEF.md
# Host I/O Address and Command Decoder

This block sits between the host's I/O instruction bus and up to eight peripheral channels. Each host I/O instruction carries an 8-bit device field, a 16-bit word and either a write strobe or a read strobe. The block checks whether the device field addresses this unit and picks the channel. Bit 0 of the device field then says whether the transfer carries control information or program-controlled data.

A control write carries a command word. The block turns it into single-cycle per-channel strobes: channel reset, firmware branch, mode load and character-detect load. It presents the low command byte and the DMA-disable bit alongside those strobes. A branch is honoured only while the channel's firmware reports idle. When it is honoured, three control bits from the command are latched for that channel. A refused branch sets a sticky error for that channel instead. A control read returns the channel's status byte. Data writes and data reads are passed to the selected channel as strobes.

All outputs are registered and appear in the cycle after the strobe is sampled.

Top module: `ioctl_cmd_decoder`

## Requirements
- R1: A transfer is accepted only when device bits 7:6 are both 1 and device bits 5:4 equal the `addr_strap` input. Any other device field causes no strobe, no read response and no state change.
- R2: Device bits 3:1 give the channel number. Channel 0 is not a channel: a transfer to it is ignored in the same way as an address miss.
- R3: With device bit 0 = 0, a write pulses `pio_wr` for the channel and places the word on `pio_wdata`. A read pulses `pio_rd` and returns that channel's `chan_pio` byte on `rd_data` with `rd_valid`.
- R4: A control write with command bit 8 set pulses `cmd_reset` for the channel one cycle later. It also clears the channel's sticky branch error, unless R7 sets it in the same write.
- R5: A control write with command bit 9 set, while the channel's `chan_idle` is 1, pulses `cmd_branch` for that channel one cycle later. `cmd_field[7:4]` then carries the branch address and `cmd_dma_off` carries command bit 15. At most one branch strobe is high at a time.
- R6: An accepted branch stores command bits 13:11 into that channel's slot of `ctl_bits` (bits 3c+2:3c for channel c). The slot changes at no other time.
- R7: A branch command received while `chan_idle` is 0 produces no branch strobe and leaves `ctl_bits` unchanged. It sets that channel's `br_err` flag, which stays set until a later reset command for that channel.
- R8: Command bit 10 pulses `cmd_mode_ld`, with the mode bits on `cmd_field[3:0]`. Command bit 14 pulses `cmd_char_ld`, with the special character on `cmd_field[7:0]`. `cmd_field` and `cmd_dma_off` are updated by every accepted control write.
- R9: A control read (device bit 0 = 1) returns the channel's `chan_status` byte on `rd_data` with a one-cycle `rd_valid` in the following cycle. `rd_data` holds its value until the next read.
- R10: A cycle in which `host_wr` and `host_rd` are both high is ignored entirely.
- R11: After reset all strobes, `cmd_field`, `cmd_dma_off`, `ctl_bits`, `br_err`, `pio_wdata`, `rd_valid` and `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_strap | input | 2 | Strapped low pair of the unit address |
| host_dev | input | 8 | Device address and function field |
| host_word | input | 16 | Command or data word for writes |
| host_wr | input | 1 | Host output strobe |
| host_rd | input | 1 | Host input strobe |
| chan_idle | input | 8 | Per-channel firmware-at-idle flags |
| chan_status | input | 64 | Per-channel status bytes, channel c at bits 8c+7:8c |
| chan_pio | input | 64 | Per-channel program data bytes, same packing |
| cmd_reset | output | 8 | Per-channel reset pulse |
| cmd_branch | output | 8 | Per-channel branch pulse |
| cmd_mode_ld | output | 8 | Per-channel mode load pulse |
| cmd_char_ld | output | 8 | Per-channel special-character load pulse |
| cmd_field | output | 8 | Low byte of the last accepted command |
| cmd_dma_off | output | 1 | DMA-disable bit of the last accepted command |
| ctl_bits | output | 24 | Latched 3-bit control value per channel |
| br_err | output | 8 | Sticky refused-branch flag per channel |
| pio_wr | output | 8 | Per-channel data write pulse |
| pio_rd | output | 8 | Per-channel data read pulse |
| pio_wdata | output | 16 | Word of the last data write |
| rd_valid | output | 1 | Read response valid pulse |
| rd_data | output | 8 | Read response byte |

## Verification
The hardest cases to reach from the ports are the interactions within a single command word. One is a branch refused because the channel is busy while the same word also requests a reset: the error must end up set, not cleared. Another is an accepted branch that must leave every other channel's control slot untouched. The stimulus drives `chan_idle` independently of the command stream and issues words with several command bits set together. It also places directed sequences (refuse, reset-and-refuse, plain reset, accept) on one channel. A behavioural model then tracks per-channel error and control state over the whole run.

// File: rtl/ioctl_pkg.sv
// Shared constants and types for the host I/O command decoder.
// Assumes the fixed 8-bit device field layout: unit id in 7:4, channel in 3:1,
// function in bit 0, and a 16-bit command word.
package ioctl_pkg;
    localparam int DEV_W     = 8;
    localparam int WORD_W    = 16;
    localparam int CH_BITS   = 3;
    localparam int NCH       = 1 << CH_BITS;
    localparam int CTL_W     = 3;
    localparam int FIELD_W   = 8;

    // Command word bit positions; the channel firmware decodes these.
    localparam int B_RESET   = 8;
    localparam int B_BRANCH  = 9;
    localparam int B_MODE    = 10;
    localparam int B_CTL_LO  = 11;
    localparam int B_CHAR    = 14;
    localparam int B_DMA_OFF = 15;

    typedef struct packed {
        logic               hit;
        logic               is_ctl;
        logic [CH_BITS-1:0] chan;
    } dev_sel_t;
endpackage

// File: rtl/ioctl_addr_match.sv
// Combinational decode of the device field.
// hit: unit id is 2'b11 followed by the strapped pair.
// Assumes the caller qualifies the result with a strobe.
module ioctl_addr_match
    import ioctl_pkg::*;
(
    input  logic [DEV_W-1:0] dev,
    input  logic [1:0]       strap,
    output dev_sel_t         sel
);
    // Split the field into match, channel and function.
    always_comb begin
        sel.hit    = (dev[7:6] == 2'b11) && (dev[5:4] == strap);
        sel.chan   = dev[CH_BITS:1];
        sel.is_ctl = dev[0];
    end
endmodule

// File: rtl/ioctl_chan_ctl.sv
// Per-channel command executor. It turns one accepted command write into
// registered pulses, and keeps the latched control bits and the sticky error.
// Assumes ctl_wr and dat_wr are already gated by address, channel and strobe rules.
module ioctl_chan_ctl
    import ioctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             dat_wr,
    input  logic             do_reset,
    input  logic             do_branch,
    input  logic             do_mode,
    input  logic             do_char,
    input  logic [CTL_W-1:0] ctl_val,
    input  logic             idle,
    output logic             reset_p,
    output logic             branch_p,
    output logic             mode_p,
    output logic             char_p,
    output logic             pio_wr_p,
    output logic [CTL_W-1:0] ctl_q,
    output logic             err_q
);
    logic br_ok;
    logic br_refused;

    // Split a branch request into honoured and refused by firmware idle.
    always_comb begin
        br_ok      = ctl_wr && do_branch && idle;
        br_refused = ctl_wr && do_branch && !idle;
    end

    // Single-cycle strobes for this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_p  <= 1'b0;
            branch_p <= 1'b0;
            mode_p   <= 1'b0;
            char_p   <= 1'b0;
            pio_wr_p <= 1'b0;
        end else begin
            reset_p  <= ctl_wr && do_reset;
            branch_p <= br_ok;
            mode_p   <= ctl_wr && do_mode;
            char_p   <= ctl_wr && do_char;
            pio_wr_p <= dat_wr;
        end
    end

    // Control bits captured only on an honoured branch.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (br_ok) ctl_q <= ctl_val;
    end

    // Sticky error: a refusal sets it and wins over a reset in the same word.
    always_ff @(posedge clk) begin
        if (!rst_n)                       err_q <= 1'b0;
        else if (br_refused)              err_q <= 1'b1;
        else if (ctl_wr && do_reset)      err_q <= 1'b0;
    end
endmodule

// File: rtl/ioctl_read_mux.sv
// Read path: selects the status byte (control read) or the program data byte
// (data read) of the chosen channel and registers it with a valid pulse.
// Assumes rd_go is already qualified by address, channel and strobe rules.
module ioctl_read_mux
    import ioctl_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_go,
    input  logic                  is_ctl,
    input  logic [CH_BITS-1:0]    chan,
    input  logic [NCH*STAT_W-1:0] status,
    input  logic [NCH*STAT_W-1:0] pio,
    output logic                  rd_valid,
    output logic [STAT_W-1:0]     rd_data,
    output logic [NCH-1:0]        pio_rd
);
    logic [STAT_W-1:0] stat_pick;
    logic [STAT_W-1:0] pio_pick;

    // Pick the addressed channel's bytes.
    always_comb begin
        stat_pick = '0;
        pio_pick  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (chan == CH_BITS'(i)) begin
                stat_pick = status[i*STAT_W +: STAT_W];
                pio_pick  = pio[i*STAT_W +: STAT_W];
            end
        end
    end

    // Register the response and the data-read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            pio_rd   <= '0;
        end else begin
            rd_valid <= rd_go;
            pio_rd   <= (rd_go && !is_ctl) ? (NCH'(1) << chan) : '0;
            if (rd_go) rd_data <= is_ctl ? stat_pick : pio_pick;
        end
    end
endmodule

// File: rtl/ioctl_cmd_decoder.sv
// Top of the host I/O address and command decoder. It qualifies host strobes
// against the unit address, fans accepted writes out to per-channel executors,
// and routes reads. Assumes host_wr/host_rd are single-cycle strobes sampled on clk.
module ioctl_cmd_decoder
    import ioctl_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            addr_strap,
    input  logic [DEV_W-1:0]      host_dev,
    input  logic [WORD_W-1:0]     host_word,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [NCH-1:0]        chan_idle,
    input  logic [NCH*STAT_W-1:0] chan_status,
    input  logic [NCH*STAT_W-1:0] chan_pio,
    output logic [NCH-1:0]        cmd_reset,
    output logic [NCH-1:0]        cmd_branch,
    output logic [NCH-1:0]        cmd_mode_ld,
    output logic [NCH-1:0]        cmd_char_ld,
    output logic [FIELD_W-1:0]    cmd_field,
    output logic                  cmd_dma_off,
    output logic [NCH*CTL_W-1:0]  ctl_bits,
    output logic [NCH-1:0]        br_err,
    output logic [NCH-1:0]        pio_wr,
    output logic [NCH-1:0]        pio_rd,
    output logic [WORD_W-1:0]     pio_wdata,
    output logic                  rd_valid,
    output logic [STAT_W-1:0]     rd_data
);
    dev_sel_t       sel;
    logic           go;
    logic           ctl_wr;
    logic           dat_wr;
    logic           rd_go;
    logic [NCH-1:0] ch_hit;

    ioctl_addr_match u_match (
        .dev   (host_dev),
        .strap (addr_strap),
        .sel   (sel)
    );

    // Accept exactly one strobe, a matching unit and a non-zero channel.
    always_comb begin
        go     = (host_wr ^ host_rd) && sel.hit && (sel.chan != '0);
        ctl_wr = go && host_wr && sel.is_ctl;
        dat_wr = go && host_wr && !sel.is_ctl;
        rd_go  = go && host_rd;
        ch_hit = NCH'(1) << sel.chan;
    end

    // Shared command fields and data word presented with the strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_field   <= '0;
            cmd_dma_off <= 1'b0;
            pio_wdata   <= '0;
        end else begin
            if (ctl_wr) begin
                cmd_field   <= host_word[FIELD_W-1:0];
                cmd_dma_off <= host_word[B_DMA_OFF];
            end
            if (dat_wr) pio_wdata <= host_word;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        ioctl_chan_ctl u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_wr    (ctl_wr && ch_hit[g]),
            .dat_wr    (dat_wr && ch_hit[g]),
            .do_reset  (host_word[B_RESET]),
            .do_branch (host_word[B_BRANCH]),
            .do_mode   (host_word[B_MODE]),
            .do_char   (host_word[B_CHAR]),
            .ctl_val   (host_word[B_CTL_LO +: CTL_W]),
            .idle      (chan_idle[g]),
            .reset_p   (cmd_reset[g]),
            .branch_p  (cmd_branch[g]),
            .mode_p    (cmd_mode_ld[g]),
            .char_p    (cmd_char_ld[g]),
            .pio_wr_p  (pio_wr[g]),
            .ctl_q     (ctl_bits[g*CTL_W +: CTL_W]),
            .err_q     (br_err[g])
        );
    end

    ioctl_read_mux #(.STAT_W(STAT_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_go    (rd_go),
        .is_ctl   (sel.is_ctl),
        .chan     (sel.chan),
        .status   (chan_status),
        .pio      (chan_pio),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .pio_rd   (pio_rd)
    );
endmodule

// File: rtl/ioctl_cmd_decoder_chk.sv
// Assertion checker for ioctl_cmd_decoder, attached by bind below.
// Assumes the decoder's synchronous active-low reset.
module ioctl_cmd_decoder_chk
    import ioctl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [NCH-1:0]       chan_idle,
    input logic [NCH-1:0]       cmd_reset,
    input logic [NCH-1:0]       cmd_branch,
    input logic [NCH-1:0]       cmd_mode_ld,
    input logic [NCH-1:0]       cmd_char_ld,
    input logic [NCH*CTL_W-1:0] ctl_bits,
    input logic [NCH-1:0]       br_err,
    input logic [NCH-1:0]       pio_wr,
    input logic [NCH-1:0]       pio_rd,
    input logic                 rd_valid
);
    p_branch_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_branch));

    p_chan0_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_reset[0] || cmd_branch[0] || cmd_mode_ld[0] || cmd_char_ld[0] || pio_wr[0] || pio_rd[0]));

    p_no_rd_with_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((pio_wr | cmd_reset | cmd_branch | cmd_mode_ld | cmd_char_ld) == '0));

    p_pio_rd_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|pio_rd) |-> rd_valid);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        p_branch_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_branch[i] |-> $past(chan_idle[i]));

        p_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ctl_bits[i*CTL_W +: CTL_W]) |-> cmd_branch[i]);

        p_err_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(br_err[i]) |-> cmd_reset[i]);

        p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(br_err[i]) |-> !cmd_branch[i]);
    end
endmodule

bind ioctl_cmd_decoder ioctl_cmd_decoder_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_idle   (chan_idle),
    .cmd_reset   (cmd_reset),
    .cmd_branch  (cmd_branch),
    .cmd_mode_ld (cmd_mode_ld),
    .cmd_char_ld (cmd_char_ld),
    .ctl_bits    (ctl_bits),
    .br_err      (br_err),
    .pio_wr      (pio_wr),
    .pio_rd      (pio_rd),
    .rd_valid    (rd_valid)
);

// File: tb/ioctl_cmd_decoder_tb_top.sv
module ioctl_cmd_decoder_tb_top;
    import ioctl_pkg::*;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]        addr_strap = 2'b11;
    logic [7:0]        host_dev = '0;
    logic [15:0]       host_word = '0;
    logic              host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]        chan_idle = '0;
    logic [63:0]       chan_status = '0, chan_pio = '0;
    logic [7:0]        cmd_reset, cmd_branch, cmd_mode_ld, cmd_char_ld, br_err, pio_wr, pio_rd;
    logic [7:0]        cmd_field, rd_data;
    logic              cmd_dma_off, rd_valid;
    logic [23:0]       ctl_bits;
    logic [15:0]       pio_wdata;

    ioctl_cmd_decoder dut_i (.*);

    // Behavioural reference state.
    logic [7:0]  m_rst, m_br, m_mode, m_char, m_err, m_pw, m_pr;
    logic [2:0]  m_ctl [8];
    logic [7:0]  m_field, m_rdata;
    logic        m_dma, m_rdv;
    logic [15:0] m_wdata;
    bit          started = 0;
    int n_cmp = 0, n_bad = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: one update per rising edge.
    always @(posedge clk) begin
        started <= 1;
        m_rst = 0; m_br = 0; m_mode = 0; m_char = 0; m_pw = 0; m_pr = 0; m_rdv = 0;
        if (!rst_n) begin
            m_err = 0; m_field = 0; m_rdata = 0; m_dma = 0; m_wdata = 0;
            for (int i = 0; i < 8; i++) m_ctl[i] = 0;
        end else begin
            int c;
            bit ok;
            c  = int'(host_dev[3:1]);
            ok = (host_dev[7:6] == 2'b11) && (host_dev[5:4] == addr_strap) && (c != 0) && (host_wr != host_rd);
            if (ok && host_wr && host_dev[0]) begin
                m_field = host_word[7:0];
                m_dma   = host_word[15];
                if (host_word[8])  m_rst[c] = 1;
                if (host_word[10]) m_mode[c] = 1;
                if (host_word[14]) m_char[c] = 1;
                if (host_word[9] && chan_idle[c]) begin
                    m_br[c] = 1;
                    m_ctl[c] = host_word[13:11];
                end
                if (host_word[9] && !chan_idle[c]) m_err[c] = 1;
                else if (host_word[8]) m_err[c] = 0;
            end else if (ok && host_wr) begin
                m_pw[c] = 1;
                m_wdata = host_word;
            end else if (ok && host_rd) begin
                m_rdv = 1;
                m_rdata = host_dev[0] ? chan_status[c*8 +: 8] : chan_pio[c*8 +: 8];
                if (!host_dev[0]) m_pr[c] = 1;
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        if (started) begin
            logic [23:0] e_ctl;
            for (int i = 0; i < 8; i++) e_ctl[i*3 +: 3] = m_ctl[i];
            check("R4 cmd_reset", cmd_reset, m_rst);
            check("R5 cmd_branch", cmd_branch, m_br);
            check("R5 cmd_field/dma", {cmd_dma_off, cmd_field}, {m_dma, m_field});
            check("R6 ctl_bits", ctl_bits, e_ctl);
            check("R7 br_err", br_err, m_err);
            check("R8 mode/char", {cmd_mode_ld, cmd_char_ld}, {m_mode, m_char});
            check("R3 pio", {pio_wr, pio_rd, pio_wdata}, {m_pw, m_pr, m_wdata});
            check("R9 read", {rd_valid, rd_data}, {m_rdv, m_rdata});
        end
    end

    function automatic logic [47:0] pulses();
        return {cmd_reset, cmd_branch, cmd_mode_ld, cmd_char_ld, pio_wr, pio_rd};
    endfunction

    task automatic op(input bit w, input bit r, input logic [7:0] dev, input logic [15:0] word);
        @(negedge clk);
        host_wr = w; host_rd = r; host_dev = dev; host_word = word;
        @(negedge clk);
        host_wr = 0; host_rd = 0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            chan_status[i*8 +: 8] = 8'(8'h30 + i);
            chan_pio[i*8 +: 8]    = 8'(8'hA0 + i);
        end
        repeat (3) @(negedge clk);
        // R11: reset state.
        check("R11 reset outputs", {pulses(), cmd_field, cmd_dma_off, br_err, pio_wdata, rd_valid, rd_data}, '0);
        check("R11 ctl_bits", ctl_bits, '0);
        rst_n = 1;
        chan_idle = 8'hFF;
        // R1: unit id bits 7:6 not both 1.
        op(1, 0, 8'hB3, 16'h0300);
        check("R1 upper-bit miss", pulses(), '0);
        // R1: strap mismatch.
        op(1, 0, 8'hE3, 16'h0300);
        check("R1 strap miss", pulses(), '0);
        // R2: channel 0.
        op(1, 0, 8'hF1, 16'h4700);
        check("R2 channel zero", pulses(), '0);
        // R10: both strobes.
        op(1, 1, 8'hF3, 16'h0300);
        check("R10 both strobes", {pulses(), rd_valid}, '0);
        // R7 refused branch, then reset plus refused branch, then plain reset (R4).
        chan_idle[2] = 0;
        op(1, 0, 8'hF5, 16'h3A50);
        check("R7 refused branch", {cmd_branch[2], br_err[2]}, 2'b01);
        op(1, 0, 8'hF5, 16'h0300);
        check("R7 error wins over reset", br_err[2], 1'b1);
        op(1, 0, 8'hF5, 16'h0100);
        check("R4 reset clears error", {cmd_reset[2], br_err[2]}, 2'b10);
        chan_idle[2] = 1;
        op(1, 0, 8'hF5, 16'hAE70);   // R5/R6: branch with ctl 5, dma off
        check("R5 branch accepted", {cmd_branch[2], cmd_dma_off, cmd_field[7:4]}, {1'b1, 1'b1, 4'h7});
        check("R6 ctl latched", ctl_bits[8:6], 3'd5);
        op(1, 0, 8'hFF, 16'h44C9);   // R8 mode + char on channel 7
        check("R8 mode/char", {cmd_mode_ld[7], cmd_char_ld[7], cmd_field}, {2'b11, 8'hC9});
        op(0, 1, 8'hFB, 16'h0);      // R9 status read channel 5
        check("R9 status", {rd_valid, rd_data}, {1'b1, 8'h35});
        op(0, 1, 8'hFA, 16'h0);      // R3 data read channel 5
        check("R3 data read", {pio_rd[5], rd_data}, {1'b1, 8'hA5});
        op(1, 0, 8'hF6, 16'hBEEF);   // R3 data write channel 3
        check("R3 data write", {pio_wr[3], pio_wdata}, {1'b1, 16'hBEEF});
        // Random traffic, with a strap change midway.
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] d;
            if (k == 1500) addr_strap = 2'b01;
            d = 8'($urandom);
            if ($urandom_range(3) != 0) d[7:4] = {2'b11, addr_strap};
            chan_idle = 8'($urandom);
            chan_status = {$urandom, $urandom};
            chan_pio    = {$urandom, $urandom};
            case ($urandom_range(9))
                0: op(1, 1, d, 16'($urandom));
                1, 2, 3: op(0, 1, d, 16'($urandom));
                default: op(1, 0, d, 16'($urandom));
            endcase
        end
        @(negedge clk);
        summary();
    end
endmodule